// File: doc/BRIEF.md
# SMBus Bus Timeout Monitor

This block watches the sampled clock and data lines of a two-wire system management bus and reports two kinds of timeout. The first is a stuck-low clock. A cycle counter is held at its reload value while the clock line is high. It advances on every system clock while the clock line is low. If it reaches a limit equal to 25 ms by default, it raises a one-cycle timeout pulse. The second is an idle bus. While both lines stay high, a counter counts ticks from an external clock-source divider. Once more than a set number of source periods have passed, the bus is declared free. That event is reported on the same flag as a real STOP condition.

Both detectors have their own enable input. The block also recognises a genuine STOP, which is a data rise while the clock line stays high. It merges every event into a single interrupt request, so software sees one interface for a real STOP and for an emulated one. Each detector is a small state machine. The low timer has the states LT_IDLE, LT_COUNT and LT_EXPIRED. Its transitions are start-of-low (LT_IDLE to LT_COUNT), limit-reached (LT_COUNT to LT_EXPIRED) and reload (any state to LT_IDLE when the clock line is high or the timer is disabled). The free detector has the states FB_BUSY, FB_WAIT and FB_FREE. Its transitions are both-high (FB_BUSY to FB_WAIT), tick-limit-reached (FB_WAIT to FB_FREE) and line-low-or-disabled (any state to FB_BUSY).

Top module: `smbus_timeout_mon`

## Requirements
- R1: During and right after reset, low_tmo_pulse, stop_flag and irq are all 0.
- R2: With low_tmo_en = 1, low_tmo_pulse is 1 for exactly the one cycle that follows the LOW_LIMIT-th consecutive rising clock edge at which scl_in was sampled 0. LOW_LIMIT = CLK_FREQ_HZ * LOW_TIMEOUT_US / 1,000,000, and its minimum is 2.
- R3: A single rising edge with scl_in sampled 1 reloads the low counter. A low run shorter than LOW_LIMIT samples never pulses, and the count starts again from zero at the next low sample.
- R4: The low timeout fires at most once per continuous low interval. It can fire again only after scl_in has been sampled 1.
- R5: With low_tmo_en = 0, no low timeout is produced. Once the enable goes to 1 while scl_in is low, the pulse follows the LOW_LIMIT-th low sample taken with the enable set.
- R6: With free_tmo_en = 1, stop_flag is 1 for one cycle after the edge at which the (FREE_PERIODS+1)-th src_tick is sampled. Only edges where scl_in and sda_in are both 1 count, and the tick sampled at the first both-high edge counts.
- R7: Any edge with scl_in or sda_in sampled 0 clears the free tick count. Ticks sampled while a line is low are not counted.
- R8: The free timeout fires at most once per continuous both-high interval.
- R9: With free_tmo_en = 0, no stop_flag is produced by an idle bus.
- R10: A real STOP sets stop_flag for one cycle. A real STOP means sda_in goes from sampled 0 to sampled 1 across two consecutive edges while scl_in is sampled 1 at both edges. A data rise while scl_in is low produces nothing.
- R11: irq is 1 in exactly the cycles in which low_tmo_pulse or stop_flag is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| low_tmo_en | input | 1 | Enables the clock-stuck-low timeout |
| free_tmo_en | input | 1 | Enables the idle-bus (free) timeout |
| scl_in | input | 1 | Synchronised clock line level |
| sda_in | input | 1 | Synchronised data line level |
| src_tick | input | 1 | One-cycle tick per bus clock-source period |
| low_tmo_pulse | output | 1 | One-cycle clock-low timeout event |
| stop_flag | output | 1 | One-cycle STOP event, real or emulated by free timeout |
| irq | output | 1 | Interrupt request, one cycle per event |

## Verification
The bench builds the block with CLK_FREQ_HZ = 1,000,000, LOW_TIMEOUT_US = 20 and FREE_PERIODS = 3. This gives a 20-cycle low limit and a 4-tick free limit. At that size the exact firing cycle, the one-short-of-limit case and the re-arm after a reload can all be observed cycle by cycle. The default 25 ms limit would need millions of cycles. The free detector is driven with ticks every cycle, every second cycle and every third cycle, so tick counting is separated from cycle counting.

// File: rtl/smbus_tmo_pkg.sv
package smbus_tmo_pkg;

    typedef enum logic [1:0] {
        LT_IDLE,
        LT_COUNT,
        LT_EXPIRED
    } low_state_t;

    typedef enum logic [1:0] {
        FB_BUSY,
        FB_WAIT,
        FB_FREE
    } free_state_t;

endpackage

// File: rtl/smbus_low_timer.sv
module smbus_low_timer
    import smbus_tmo_pkg::*;
#(
    parameter int unsigned LIMIT = 2500000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic scl,
    output logic expire_pulse
);
    localparam int unsigned CW = $clog2(LIMIT + 1);

    low_state_t    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    // next state: reload while clock line is high or timer disabled
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (!enable || scl) begin
            state_d = LT_IDLE;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                LT_IDLE: begin
                    state_d = LT_COUNT;
                    cnt_d   = CW'(1);
                end
                LT_COUNT: begin
                    if (cnt_q == CW'(LIMIT - 1)) begin
                        state_d = LT_EXPIRED;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                LT_EXPIRED: state_d = LT_EXPIRED;
                default:    state_d = LT_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LT_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            expire_pulse <= 1'b0;
        end else begin
            expire_pulse <= (state_q == LT_COUNT) && (state_d == LT_EXPIRED);
        end
    end

endmodule

// File: rtl/smbus_free_detect.sv
module smbus_free_detect
    import smbus_tmo_pkg::*;
#(
    parameter int unsigned TICKS = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic scl,
    input  logic sda,
    input  logic tick,
    output logic free_pulse
);
    localparam int unsigned TW = $clog2(TICKS + 1);

    free_state_t   state_q, state_d;
    logic [TW-1:0] tcnt_q, tcnt_d;
    logic          idle_lines;

    assign idle_lines = scl && sda;

    always_comb begin
        state_d = state_q;
        tcnt_d  = tcnt_q;
        if (!enable || !idle_lines) begin
            state_d = FB_BUSY;
            tcnt_d  = '0;
        end else begin
            unique case (state_q)
                FB_BUSY: begin
                    state_d = FB_WAIT;
                    tcnt_d  = tick ? TW'(1) : '0;
                end
                FB_WAIT: begin
                    if (tick) begin
                        if (tcnt_q == TW'(TICKS - 1)) begin
                            state_d = FB_FREE;
                        end else begin
                            tcnt_d = tcnt_q + 1'b1;
                        end
                    end
                end
                FB_FREE: state_d = FB_FREE;
                default: state_d = FB_BUSY;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FB_BUSY;
            tcnt_q  <= '0;
        end else begin
            state_q <= state_d;
            tcnt_q  <= tcnt_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            free_pulse <= 1'b0;
        end else begin
            free_pulse <= (state_q == FB_WAIT) && (state_d == FB_FREE);
        end
    end

endmodule

// File: rtl/smbus_stop_edge.sv
module smbus_stop_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic scl,
    input  logic sda,
    output logic stop_pulse
);
    logic scl_q, sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q      <= 1'b1;
            sda_q      <= 1'b1;
            stop_pulse <= 1'b0;
        end else begin
            scl_q      <= scl;
            sda_q      <= sda;
            stop_pulse <= scl_q && scl && !sda_q && sda;
        end
    end

endmodule

// File: rtl/smbus_timeout_mon.sv
module smbus_timeout_mon #(
    parameter int unsigned CLK_FREQ_HZ    = 100000000,
    parameter int unsigned LOW_TIMEOUT_US = 25000,
    parameter int unsigned FREE_PERIODS   = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic low_tmo_en,
    input  logic free_tmo_en,
    input  logic scl_in,
    input  logic sda_in,
    input  logic src_tick,
    output logic low_tmo_pulse,
    output logic stop_flag,
    output logic irq
);
    localparam longint unsigned LOW_CYC =
        (longint'(CLK_FREQ_HZ) * longint'(LOW_TIMEOUT_US)) / 64'd1000000;
    localparam int unsigned LOW_LIMIT  = (LOW_CYC < 64'd2) ? 2 : 32'(LOW_CYC);
    localparam int unsigned FREE_TICKS = (FREE_PERIODS < 1) ? 2 : FREE_PERIODS + 1;

    logic free_evt;
    logic real_stop;

    smbus_low_timer #(.LIMIT(LOW_LIMIT)) i_low_timer (
        .clk          (clk),
        .rst_n        (rst_n),
        .enable       (low_tmo_en),
        .scl          (scl_in),
        .expire_pulse (low_tmo_pulse)
    );

    smbus_free_detect #(.TICKS(FREE_TICKS)) i_free_detect (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (free_tmo_en),
        .scl        (scl_in),
        .sda        (sda_in),
        .tick       (src_tick),
        .free_pulse (free_evt)
    );

    smbus_stop_edge i_stop_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl        (scl_in),
        .sda        (sda_in),
        .stop_pulse (real_stop)
    );

    assign stop_flag = free_evt || real_stop;
    assign irq       = low_tmo_pulse || stop_flag;

endmodule

// File: rtl/smbus_timeout_mon_chk.sv
module smbus_timeout_mon_chk (
    input logic clk,
    input logic rst_n,
    input logic low_tmo_en,
    input logic scl_in,
    input logic sda_in,
    input logic low_tmo_pulse,
    input logic stop_flag
);
    AST_LOW_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        low_tmo_pulse |=> !low_tmo_pulse); // R4

    AST_LOW_NEEDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        low_tmo_pulse |-> !$past(scl_in)); // R2

    AST_LOW_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        low_tmo_pulse |-> $past(low_tmo_en)); // R5

    AST_STOP_LINES_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        stop_flag |-> ($past(scl_in) && $past(sda_in))); // R6

    AST_STOP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        stop_flag |=> !stop_flag); // R8

endmodule

bind smbus_timeout_mon smbus_timeout_mon_chk i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .low_tmo_en    (low_tmo_en),
    .scl_in        (scl_in),
    .sda_in        (sda_in),
    .low_tmo_pulse (low_tmo_pulse),
    .stop_flag     (stop_flag)
);

// File: tb/test_smbus_timeout_mon.sv
module test_smbus_timeout_mon;
    localparam int LIMIT = 20;
    localparam int FP    = 3;
    localparam int FT    = FP + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic low_tmo_en = 1'b0, free_tmo_en = 1'b0;
    logic scl_in = 1'b1, sda_in = 1'b1, src_tick = 1'b0;
    logic low_tmo_pulse, stop_flag, irq;

    int checks = 0, errors = 0;
    int n_lo, first_lo, n_st, first_st, irq_bad = 0;
    int tick_div = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    smbus_timeout_mon #(
        .CLK_FREQ_HZ(1000000), .LOW_TIMEOUT_US(LIMIT), .FREE_PERIODS(FP)
    ) i_smbus_timeout_mon (
        .clk(clk), .rst_n(rst_n), .low_tmo_en(low_tmo_en), .free_tmo_en(free_tmo_en),
        .scl_in(scl_in), .sda_in(sda_in), .src_tick(src_tick),
        .low_tmo_pulse(low_tmo_pulse), .stop_flag(stop_flag), .irq(irq)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // step n cycles from a negedge, recording events (1-based step index)
    task automatic run(input int n);
        n_lo = 0; first_lo = 0; n_st = 0; first_st = 0;
        for (int i = 0; i < n; i++) begin
            src_tick = (tick_div > 0) && ((i % tick_div) == tick_div - 1);
            @(posedge clk);
            @(negedge clk);
            if (low_tmo_pulse) begin n_lo++; if (first_lo == 0) first_lo = i + 1; end
            if (stop_flag)     begin n_st++; if (first_st == 0) first_st = i + 1; end
            if (irq !== (low_tmo_pulse | stop_flag)) irq_bad++;
        end
        src_tick = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(low_tmo_pulse == 0 && stop_flag == 0 && irq == 0, "R1", "outputs in reset",
            {low_tmo_pulse, stop_flag, irq}, 0);
        rst_n = 1'b1;
        run(2);
        chk(n_lo == 0 && n_st == 0, "R1", "events after reset", n_lo + n_st, 0);
    endtask

    task automatic t_low_basic();
        low_tmo_en = 1; free_tmo_en = 0; sda_in = 1; tick_div = 0;
        scl_in = 0;
        run(LIMIT + 5);
        chk(n_lo == 1, "R2", "low pulses", n_lo, 1);
        chk(first_lo == LIMIT, "R2", "low pulse cycle", first_lo, LIMIT);
        run(3 * LIMIT);
        chk(n_lo == 0, "R4", "no repeat while low", n_lo, 0);
        scl_in = 1; run(2);
        scl_in = 0; run(LIMIT + 2);
        chk(n_lo == 1 && first_lo == LIMIT, "R4", "re-armed after high", first_lo, LIMIT);
        scl_in = 1; run(2);
    endtask

    task automatic t_low_interrupt();
        low_tmo_en = 1; scl_in = 0;
        run(LIMIT - 1);
        chk(n_lo == 0, "R3", "one short of limit", n_lo, 0);
        scl_in = 1; run(1);
        scl_in = 0; run(LIMIT - 1);
        chk(n_lo == 0, "R3", "count restarted", n_lo, 0);
        run(1);
        chk(n_lo == 1, "R3", "fires at full run", n_lo, 1);
        scl_in = 1; run(2);
    endtask

    task automatic t_low_disabled();
        low_tmo_en = 0; scl_in = 0;
        run(2 * LIMIT);
        chk(n_lo == 0, "R5", "disabled no pulse", n_lo, 0);
        low_tmo_en = 1;
        run(LIMIT + 2);
        chk(n_lo == 1 && first_lo == LIMIT, "R5", "count from enable", first_lo, LIMIT);
        scl_in = 1; low_tmo_en = 0; run(2);
    endtask

    task automatic t_free_basic();
        free_tmo_en = 1; low_tmo_en = 0; sda_in = 1;
        tick_div = 0; scl_in = 0; run(1);
        scl_in = 1; tick_div = 3;
        run(20);
        chk(n_st == 1, "R6", "free events", n_st, 1);
        chk(first_st == 3 * FT, "R6", "free cycle div3", first_st, 3 * FT);
        run(30);
        chk(n_st == 0, "R8", "no repeat while idle", n_st, 0);
        tick_div = 1; scl_in = 0; run(1);
        scl_in = 1; run(FT + 2);
        chk(n_st == 1 && first_st == FT, "R6", "free cycle div1", first_st, FT);
    endtask

    task automatic t_free_clear();
        tick_div = 0; scl_in = 0; run(1);
        scl_in = 1; tick_div = 2;
        run(2 * FT - 1);
        chk(n_st == 0, "R7", "one tick short", n_st, 0);
        tick_div = 0; scl_in = 0; run(1);
        scl_in = 1; tick_div = 2;
        run(2 * FT - 1);
        chk(n_st == 0, "R7", "count cleared by low", n_st, 0);
        run(2);
        chk(n_st == 1, "R7", "fires after full count", n_st, 1);
        tick_div = 1; scl_in = 0; run(10);
        chk(n_st == 0, "R7", "ticks while low", n_st, 0);
        scl_in = 1; run(FT);
        chk(n_st == 1 && first_st == FT, "R7", "low ticks ignored", first_st, FT);
    endtask

    task automatic t_free_disabled();
        free_tmo_en = 0; tick_div = 1; scl_in = 0; run(1);
        scl_in = 1; run(20);
        chk(n_st == 0, "R9", "disabled free", n_st, 0);
        tick_div = 0;
    endtask

    task automatic t_real_stop();
        free_tmo_en = 0; low_tmo_en = 0;
        scl_in = 1; sda_in = 0; run(2);
        sda_in = 1; run(3);
        chk(n_st == 1 && first_st == 1, "R10", "real stop", first_st, 1);
        scl_in = 0; sda_in = 0; run(2);
        sda_in = 1; run(2);
        chk(n_st == 0, "R10", "rise with clock low", n_st, 0);
        scl_in = 1; run(2);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        t_reset();
        t_low_basic();
        t_low_interrupt();
        t_low_disabled();
        t_free_basic();
        t_free_clear();
        t_free_disabled();
        t_real_stop();
        chk(irq_bad == 0, "R11", "irq mismatched cycles", irq_bad, 0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule